// File: doc/BRIEF.md
# Ternary CAM Table Maintenance Sequencer

This block is the command front end that keeps the entry table of a ternary content addressable memory up to date. A host raises a request strobe together with an opcode, an entry address, a data word and a small register select field. The select field is time-multiplexed. In the strobe cycle it names a comparand register. In the cycle after that it names a result register. The sequencer then executes the command in one step. While it is executing, it does not accept a new strobe.

The commands are:
- **Single write** stores a word in an entry.
- **Dual write** stores a word in an entry and, in the same operation, presents that address to the associated SRAM with its write strobe.
- **Invalidate** frees an entry.
- **Read** returns the contents of an entry or of a result register.
- **Learn** runs without further host input. It finds the lowest-numbered free entry and copies the selected comparand into it. It then records the index in the selected result register and drives the SRAM write strobe with that index. If no entry is free, it raises a full indication and writes nothing.

For table initialisation, an advance input writes the data word at an internal address counter and then steps the counter. This allows bursts of any length without sending new addresses. After reset, the block is disabled and its index outputs are not driven. An enable command must be issued before any other command takes effect.

The search array is represented here as a plain store of data words with a valid bit per entry.

Top module: `cam_maint_ctrl`

## Requirements
- R1: After reset, `idx_oe_o`, `done_o`, `sram_we_o` and `full_o` are 0, every entry is invalid and the block is disabled. While disabled, every command except enable (opcode 0) and every advance pulse is ignored, and no `done_o` is given. An enable command pulses `done_o` and sets `idx_oe_o` to 1.
- R2: Opcode encoding: 0 enable, 1 write, 2 comparand load, 3 learn, 4 dual write, 5 invalidate, 6 entry read, 7 result read. A strobe seen at clock edge E latches the opcode, address, data and comparand select. `sel_i` at edge E+1 is the result select. The command executes at E+1, and its outputs, with a one-cycle `done_o` pulse, are valid between E+1 and E+2. A strobe present at E+1 is ignored.
- R3: Write (opcode 1) stores the data in the addressed entry and marks it valid. An entry read (opcode 6) returns its data on `rd_data_o` and its valid bit on `rd_vld_o`.
- R4: An advance pulse in an idle cycle with no strobe stores `data_i` at the burst counter, marks that entry valid and increments the counter modulo the table depth, with no limit on the burst length. Write and dual write load the counter with their address plus one.
- R5: Learn (opcode 3) with a free entry writes the selected comparand into the lowest-indexed invalid entry, marks it valid, stores the index in the selected result register, drives that index on `idx_o` and pulses `sram_we_o`.
- R6: Learn with no free entry pulses `done_o` and `full_o`, keeps `sram_we_o` low, and changes neither the table nor any result register.
- R7: Dual write (opcode 4) stores the data in the addressed entry, drives the address on `idx_o` and pulses `sram_we_o` in the same cycle as `done_o`.
- R8: Invalidate (opcode 5) clears the entry's valid bit, so that a later learn may choose that entry.
- R9: Comparand load (opcode 2) writes the data to the comparand register named in the strobe cycle. Result read (opcode 7) returns the result register named in the second cycle, zero-extended, on `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| instr_i | input | 3 | Opcode |
| addr_i | input | AW (4) | Entry address |
| data_i | input | DW (16) | Command data and burst data |
| sel_i | input | SW (2) | Comparand select in the strobe cycle, result select in the next cycle |
| adv_i | input | 1 | Burst advance |
| idx_oe_o | output | 1 | Index output enable (device enabled) |
| idx_o | output | AW (4) | Index / SRAM address |
| sram_we_o | output | 1 | SRAM write strobe |
| full_o | output | 1 | Learn found no free entry |
| done_o | output | 1 | Command completion pulse |
| rd_data_o | output | DW (16) | Read data |
| rd_vld_o | output | 1 | Valid bit of the entry read |

## Verification
The hardest condition to reach is learn with a completely full table. Every one of the sixteen valid bits must be set, and some of them must have been set by learn itself, so that the lowest-free choice has been exercised across gaps. The stimulus gets there in stages. Scattered single and dual writes come first. An invalidate opens a hole that learn must refill. Then a burst wraps the counter past the last entry to fill the upper range and the bottom of the table. Three learns then fill the remaining gap. A final learn meets the full condition. After that, a further invalidate shows that learn recovers and picks the freed slot.

// File: rtl/cam_maint_pkg.sv
package cam_maint_pkg;

  typedef enum logic [2:0] {
    OP_ENABLE   = 3'd0,
    OP_WRITE    = 3'd1,
    OP_CMP_LOAD = 3'd2,
    OP_LEARN    = 3'd3,
    OP_DUAL     = 3'd4,
    OP_INVAL    = 3'd5,
    OP_READ     = 3'd6,
    OP_RES_READ = 3'd7
  } maint_op_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_EXEC = 1'b1
  } seq_state_e;

  function automatic logic writes_entry(maint_op_e op);
    return (op == OP_WRITE) || (op == OP_DUAL);
  endfunction

  function automatic logic drives_sram(maint_op_e op);
    return (op == OP_DUAL) || (op == OP_LEARN);
  endfunction

endpackage

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          free_found,
  output logic [AW-1:0] free_idx
);

  logic [DW-1:0]    ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [AW:0]      scan;

  // lowest invalid slot; MSB flags that one exists
  function automatic logic [AW:0] lowest_free(input logic [DEPTH-1:0] v);
    logic [AW:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!v[i]) r = {1'b1, AW'(i)};
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      vld_q <= '0;
    end else begin
      if (wr_en) begin
        ent_q[wr_addr] <= wr_data;
        vld_q[wr_addr] <= 1'b1;
      end
      if (clr_en) vld_q[clr_addr] <= 1'b0;
    end
  end

  assign scan       = lowest_free(vld_q);
  assign free_found = scan[AW];
  assign free_idx   = scan[AW-1:0];
  assign rd_data    = ent_q[rd_addr];
  assign rd_valid   = vld_q[rd_addr];

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> (vld_q[$past(wr_addr)] && ent_q[$past(wr_addr)] == $past(wr_data)));

  assert_clear_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !vld_q[$past(clr_addr)]);

  assert_free_is_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_found && !wr_en && !clr_en) |=> !vld_q[$past(free_idx)]);

endmodule

// File: rtl/cam_sel_regs.sv
module cam_sel_regs #(
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int NSEL = 4,
  localparam int SW  = $clog2(NSEL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [SW-1:0] cmp_sel,
  input  logic [DW-1:0] cmp_wdata,
  output logic [DW-1:0] cmp_rdata,
  input  logic          res_we,
  input  logic [SW-1:0] res_sel,
  input  logic [AW-1:0] res_wdata,
  output logic [AW-1:0] res_rdata
);

  logic [DW-1:0] cmp_q [NSEL];
  logic [AW-1:0] res_q [NSEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEL; i++) begin
        cmp_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else begin
      if (cmp_we) cmp_q[cmp_sel] <= cmp_wdata;
      if (res_we) res_q[res_sel] <= res_wdata;
    end
  end

  assign cmp_rdata = cmp_q[cmp_sel];
  assign res_rdata = res_q[res_sel];

  assert_result_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (res_q[$past(res_sel)] == $past(res_wdata)));

  assert_comparand_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (cmp_q[$past(cmp_sel)] == $past(cmp_wdata)));

endmodule

// File: rtl/cam_burst_ctr.sv
module cam_burst_ctr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);

  logic [AW-1:0] cnt_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (inc)  cnt_q <= step(cnt_q);
  end

  assign cnt = cnt_q;

  assert_ctr_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (cnt_q == AW'($past(cnt_q) + 1)));

  assert_ctr_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/cam_maint_ctrl.sv
module cam_maint_ctrl
  import cam_maint_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int NSEL  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(NSEL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [2:0]    instr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] sel_i,
  input  logic          adv_i,
  output logic          idx_oe_o,
  output logic [AW-1:0] idx_o,
  output logic          sram_we_o,
  output logic          full_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_vld_o
);

  seq_state_e    st_q;
  maint_op_e     op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [SW-1:0] csel_q;
  logic          en_q;

  // named internal events
  logic exec_go, do_learn, learn_hit, learn_full, do_wr, do_inval;
  logic do_cmp, burst_go, ent_we;
  logic [AW-1:0] ent_waddr, bcnt, free_idx, res_rdata;
  logic [DW-1:0] ent_wdata, ent_rdata, cmp_rdata;
  logic          ent_rvld, free_found;

  assign exec_go    = (st_q == SEQ_EXEC) && (en_q || op_q == OP_ENABLE);
  assign do_learn   = exec_go && (op_q == OP_LEARN);
  assign learn_hit  = do_learn && free_found;
  assign learn_full = do_learn && !free_found;
  assign do_wr      = exec_go && writes_entry(op_q);
  assign do_inval   = exec_go && (op_q == OP_INVAL);
  assign do_cmp     = exec_go && (op_q == OP_CMP_LOAD);
  assign burst_go   = (st_q == SEQ_IDLE) && !req_i && adv_i && en_q;

  assign ent_we    = do_wr || learn_hit || burst_go;
  assign ent_waddr = burst_go ? bcnt : (learn_hit ? free_idx : addr_q);
  assign ent_wdata = burst_go ? data_i : (learn_hit ? cmp_rdata : data_q);

  cam_entry_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ent_we),
    .wr_addr   (ent_waddr),
    .wr_data   (ent_wdata),
    .clr_en    (do_inval),
    .clr_addr  (addr_q),
    .rd_addr   (addr_q),
    .rd_data   (ent_rdata),
    .rd_valid  (ent_rvld),
    .free_found(free_found),
    .free_idx  (free_idx)
  );

  cam_sel_regs #(.DW(DW), .AW(AW), .NSEL(NSEL)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_we   (do_cmp),
    .cmp_sel  (csel_q),
    .cmp_wdata(data_q),
    .cmp_rdata(cmp_rdata),
    .res_we   (learn_hit),
    .res_sel  (sel_i),
    .res_wdata(free_idx),
    .res_rdata(res_rdata)
  );

  cam_burst_ctr #(.AW(AW)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (do_wr),
    .load_val(addr_q + AW'(1)),
    .inc     (burst_go),
    .cnt     (bcnt)
  );

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      op_q   <= OP_ENABLE;
      addr_q <= '0;
      data_q <= '0;
      csel_q <= '0;
      en_q   <= 1'b0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (req_i) begin
          st_q   <= SEQ_EXEC;
          op_q   <= maint_op_e'(instr_i);
          addr_q <= addr_i;
          data_q <= data_i;
          csel_q <= sel_i;
        end
        default: st_q <= SEQ_IDLE;
      endcase
      if (exec_go && op_q == OP_ENABLE) en_q <= 1'b1;
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      sram_we_o <= 1'b0;
      full_o    <= 1'b0;
      idx_o     <= '0;
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
    end else begin
      done_o    <= exec_go;
      sram_we_o <= exec_go && drives_sram(op_q) && !learn_full;
      full_o    <= learn_full;
      if (learn_hit)                       idx_o <= free_idx;
      else if (exec_go && op_q == OP_DUAL) idx_o <= addr_q;
      if (exec_go && op_q == OP_READ) begin
        rd_data_o <= ent_rdata;
        rd_vld_o  <= ent_rvld;
      end else if (exec_go && op_q == OP_RES_READ) begin
        rd_data_o <= DW'(res_rdata);
        rd_vld_o  <= 1'b1;
      end
    end
  end

  assign idx_oe_o = en_q;

  assert_exec_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_EXEC) |=> (st_q == SEQ_IDLE));

  assert_done_is_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_oe_o |-> (!done_o && !sram_we_o));

  assert_we_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we_o |-> done_o);

  assert_full_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (done_o && !sram_we_o));

  assert_learn_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    learn_hit |=> (sram_we_o && !full_o && idx_o == $past(free_idx)));

endmodule

// File: tb/sim_cam_maint_ctrl.sv
module sim_cam_maint_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, adv = 1'b0;
  logic [2:0] instr = '0;
  logic [3:0] addr = '0;
  logic [15:0] data = '0;
  logic [1:0] sel = '0;
  logic oe, we, full, done, vld;
  logic [3:0] idx;
  logic [15:0] rd;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_maint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .instr_i(instr), .addr_i(addr),
    .data_i(data), .sel_i(sel), .adv_i(adv), .idx_oe_o(oe), .idx_o(idx),
    .sram_we_o(we), .full_o(full), .done_o(done), .rd_data_o(rd), .rd_vld_o(vld)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  a;
    logic [15:0] d;
    logic [1:0]  cs;
    logic [1:0]  rs;
    logic        xwe;
    logic [3:0]  xidx;
    logic        cidx;
    logic [15:0] xrd;
    logic        crd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 4'd0, 16'hABCD, 2'd1, 2'd0, 1'b0, 4'd0, 1'b0, 16'h0,    1'b0}, // R9 load cmp1
    '{3'd2, 4'd0, 16'h1234, 2'd2, 2'd0, 1'b0, 4'd0, 1'b0, 16'h0,    1'b0}, // R9 load cmp2
    '{3'd1, 4'd0, 16'h1111, 2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'h0,    1'b0}, // R3
    '{3'd1, 4'd2, 16'h2222, 2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'h0,    1'b0}, // R3
    '{3'd3, 4'd0, 16'h0,    2'd1, 2'd3, 1'b1, 4'd1, 1'b1, 16'h0,    1'b0}, // R5 -> slot 1
    '{3'd6, 4'd1, 16'h0,    2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'hABCD, 1'b1}, // R5 copy
    '{3'd7, 4'd0, 16'h0,    2'd0, 2'd3, 1'b0, 4'd0, 1'b0, 16'h0001, 1'b1}, // R9 res3
    '{3'd3, 4'd0, 16'h0,    2'd2, 2'd0, 1'b1, 4'd3, 1'b1, 16'h0,    1'b0}, // R5 -> slot 3
    '{3'd7, 4'd0, 16'h0,    2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'h0003, 1'b1}, // R9 res0
    '{3'd7, 4'd0, 16'h0,    2'd0, 2'd3, 1'b0, 4'd0, 1'b0, 16'h0001, 1'b1}, // R9 res3 kept
    '{3'd4, 4'd9, 16'h9999, 2'd0, 2'd0, 1'b1, 4'd9, 1'b1, 16'h0,    1'b0}, // R7
    '{3'd6, 4'd9, 16'h0,    2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'h9999, 1'b1}, // R7 stored
    '{3'd5, 4'd1, 16'h0,    2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'h0,    1'b0}, // R8
    '{3'd3, 4'd0, 16'h0,    2'd2, 2'd2, 1'b1, 4'd1, 1'b1, 16'h0,    1'b0}, // R8 reuse slot 1
    '{3'd6, 4'd1, 16'h0,    2'd0, 2'd0, 1'b0, 4'd0, 1'b0, 16'h1234, 1'b1}  // R8 copy
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [3:0] a, input logic [15:0] d,
                         input logic [1:0] cs, input logic [1:0] rs, input bit hold = 1'b0);
    @(negedge clk);
    req = 1'b1; instr = op; addr = a; data = d; sel = cs;
    @(negedge clk);
    req = hold; sel = rs;
    if (hold) begin instr = 3'd1; addr = 4'd6; data = 16'h7777; end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic advance(input logic [15:0] d);
    @(negedge clk);
    adv = 1'b1; data = d;
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic learn_chk(input string tag, input logic [1:0] cs, input logic [1:0] rs,
                           input logic [3:0] xi);
    run_cmd(3'd3, 4'd0, 16'h0, cs, rs);
    chk({tag, " done"}, done, 1); chk({tag, " we"}, we, 1);
    chk({tag, " full"}, full, 0); chk({tag, " idx"}, idx, xi);
  endtask

  task automatic read_chk(input string tag, input logic [3:0] a, input logic xv, input logic [15:0] xd);
    run_cmd(3'd6, a, 16'h0, 2'd0, 2'd0);
    chk({tag, " vld"}, vld, xv);
    if (xv) chk({tag, " data"}, rd, xd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", oe, 0); chk("R1 done", done, 0); chk("R1 we", we, 0); chk("R1 full", full, 0);
    rst_n = 1'b1;
    run_cmd(3'd1, 4'd7, 16'hDEAD, 2'd0, 2'd0);
    chk("R1 write ignored while off", done, 0);
    advance(16'hBEEF);
    run_cmd(3'd0, 4'd0, 16'h0, 2'd0, 2'd0);
    chk("R1 enable done", done, 1); chk("R1 enable oe", oe, 1);
    read_chk("R1 no write while off", 4'd7, 1'b0, 16'h0);
    read_chk("R1 no advance while off", 4'd0, 1'b0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i].op, VEC[i].a, VEC[i].d, VEC[i].cs, VEC[i].rs);
      chk($sformatf("R2 vec%0d done", i), done, 1);
      chk($sformatf("R5/R7 vec%0d we", i), we, VEC[i].xwe);
      chk($sformatf("R6 vec%0d full", i), full, 0);
      if (VEC[i].cidx) chk($sformatf("R5/R7 vec%0d idx", i), idx, VEC[i].xidx);
      if (VEC[i].crd)  chk($sformatf("R3/R9 vec%0d rd", i), rd, VEC[i].xrd);
    end

    // R2: strobe during the second cycle is ignored
    run_cmd(3'd1, 4'd10, 16'h5555, 2'd0, 2'd0, 1'b1);
    chk("R2 first op done", done, 1);
    @(negedge clk);
    chk("R2 no second done", done, 0);
    read_chk("R2 second strobe ignored", 4'd6, 1'b0, 16'h0);
    read_chk("R3 write at 10", 4'd10, 1'b1, 16'h5555);

    // R4 burst from 11, wrapping past 15
    for (int k = 0; k < 7; k++) advance(16'hB000 + 16'(k));
    read_chk("R4 burst top", 4'd15, 1'b1, 16'hB004);
    read_chk("R4 burst wrap", 4'd0, 1'b1, 16'hB005);
    read_chk("R4 burst wrap2", 4'd1, 1'b1, 16'hB006);
    run_cmd(3'd1, 4'd4, 16'h4444, 2'd0, 2'd0);
    advance(16'h5A5A);
    read_chk("R4 counter load", 4'd5, 1'b1, 16'h5A5A);

    // R5 fill gap 6..8
    learn_chk("R5 gap a", 2'd1, 2'd1, 4'd6);
    learn_chk("R5 gap b", 2'd1, 2'd0, 4'd7);
    learn_chk("R5 gap c", 2'd2, 2'd2, 4'd8);

    // R6 full
    run_cmd(3'd3, 4'd0, 16'h0, 2'd2, 2'd1);
    chk("R6 done", done, 1); chk("R6 full", full, 1); chk("R6 we", we, 0);
    run_cmd(3'd7, 4'd0, 16'h0, 2'd0, 2'd1);
    chk("R6 result kept", rd, 16'h0006);
    read_chk("R6 table kept", 4'd8, 1'b1, 16'h1234);

    // R8 recovery
    run_cmd(3'd5, 4'd12, 16'h0, 2'd0, 2'd0);
    learn_chk("R8 refill", 2'd1, 2'd1, 4'd12);
    read_chk("R8 refilled data", 4'd12, 1'b1, 16'hABCD);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", oe, 0); chk("R1 done after reset", done, 0);
    rst_n = 1'b1;
    run_cmd(3'd1, 4'd3, 16'h3333, 2'd0, 2'd0);
    chk("R1 off after reset", done, 0);
    run_cmd(3'd0, 4'd0, 16'h0, 2'd0, 2'd0);
    read_chk("R1 table cleared", 4'd3, 1'b0, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule